// File: doc/BRIEF.md
# Multi-Mode Position Counter Core

This block is the counting heart of one encoder axis. A decoder upstream delivers single-cycle count strobes with a direction bit. The core keeps a wide up/down count and a limit register. The count register cannot be written or read directly: the host presets it by copying the limit register into it, and reads it through a snapshot register. A 2-bit mode field chooses how the count behaves at its boundaries. It can wrap freely, stop after its first wrap, saturate between zero and the limit, or divide by the limit plus one.

The core keeps sticky status for carry, borrow, compare-equal and index, and a sign bit. It drives two flags. The first is an active-low flag that ORs the masked events and can hold its level or give a pulse. The second shows the sign or the direction. An active-low index input can, at its falling edge, clear the count, load it or take a snapshot. All command inputs are one-cycle strobes sampled on the rising clock edge. The count strobe has no back-pressure: a strobe that arrives while counting is disabled, or in the same cycle as a clear or load, is discarded.

Top module: `poscnt_core`

## Requirements
- R1: After reset the snapshot is 0, the count is 0, status bits 7..4 and bit 0 are 0, bit 3 (count enabled) is 1, bit 2 is 0, bit 1 follows `cnt_up`, `flag_a_n` is 1 and `flag_b` is 1 with `flgb_sel`=00.
- R2: Free-running mode (`count_mode`=00): an up strobe at all-ones wraps to 0 and sets carry (status bit 7); a down strobe at 0 wraps to all-ones and sets borrow (bit 6). Borrow sets sign (bit 0) and carry clears it.
- R3: Single-cycle mode (01): a carry or borrow stops counting and drops status bit 3. Later strobes are ignored until a clear or load, which enables counting again.
- R4: Range-limit mode (10): an up strobe while the count equals the limit is blocked and sets carry. A down strobe at 0 is blocked and sets borrow. A strobe in the other direction resumes counting.
- R5: Modulo mode (11): an up strobe at count = limit gives 0 and sets carry; a down strobe at 0 gives the limit and sets borrow.
- R6: A counting step that lands on the limit value sets compare (bit 5). In modes 00 and 01 this applies in both directions; in modes 10 and 11 only when counting up. Loads never set compare.
- R7: Clear beats load, and both beat a count strobe in the same cycle. A snapshot captures the count as it was before that clock edge.
- R8: On a falling edge of `idx_n`, `idx_func` selects 00 nothing, 01 load, 10 clear, 11 snapshot. Status bit 4 is set while `idx_n` is low.
- R9: `cmd_stat_clr` clears status bits 7..4 only; an event in the same cycle keeps its bit set. `cmd_sign_set` and `cmd_sign_clr` force the sign, and clear wins if both are given.
- R10: While `count_inhibit` is 1, status bit 3 is 0 and count strobes have no effect.
- R11: With `flga_pulsed`=0, `flag_a_n` is low while any sticky bit enabled in `flga_mask` is set. The mask bits are [0] carry, [1] borrow, [2] compare and [3] index.
- R12: With `flga_pulsed`=1, each enabled event drives `flag_a_n` low for exactly the one cycle after its edge.
- R13: `flgb_sel` sets `flag_b`: 00 high, 01 sign, 10 `cnt_up` (high = up), 11 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pulse | input | 1 | One-cycle count strobe |
| cnt_up | input | 1 | Count direction, 1 = up |
| idx_n | input | 1 | Index input, active low |
| count_mode | input | 2 | Boundary mode |
| idx_func | input | 2 | Index action select |
| flga_mask | input | 4 | Event enables for flag_a_n |
| flga_pulsed | input | 1 | 1 = pulse flag, 0 = held flag |
| flgb_sel | input | 2 | flag_b source select |
| count_inhibit | input | 1 | 1 = counting disabled |
| ir_we | input | 1 | Limit register write strobe |
| ir_wdata | input | W | Limit register write data |
| cmd_clear | input | 1 | Clear the count |
| cmd_load | input | 1 | Copy the limit register into the count |
| cmd_snap | input | 1 | Copy the count into the snapshot |
| cmd_stat_clr | input | 1 | Clear sticky status |
| cmd_sign_set | input | 1 | Force sign to 1 |
| cmd_sign_clr | input | 1 | Force sign to 0 |
| snap_q | output | W | Snapshot register |
| status | output | 8 | Status byte |
| flag_a_n | output | 1 | Active-low event flag |
| flag_b | output | 1 | Sign or direction flag |

## Verification
A wrong count can only be seen at the ports after a snapshot, one edge later. For that reason every boundary scenario ends with a snapshot taken right after the strobe under test. A wrong halt or saturation decision shows up in the next strobe's result, and in status bit 3 in the same cycle. A sticky bit that was lost or stuck shows in the status byte and in the held flag one edge after the event. The pulse flag shows within one cycle whether it was wrongly stretched.

// File: rtl/poscnt_pkg.sv
package poscnt_pkg;
  typedef enum logic [1:0] {CM_FREE = 2'b00, CM_ONCE = 2'b01, CM_RANGE = 2'b10, CM_WRAP = 2'b11} cmode_t;
  typedef enum logic [1:0] {IX_OFF = 2'b00, IX_LOAD = 2'b01, IX_CLEAR = 2'b10, IX_SNAP = 2'b11} ixfn_t;
  typedef enum logic [1:0] {FB_HIGH = 2'b00, FB_SIGN = 2'b01, FB_DIR = 2'b10, FB_SPARE = 2'b11} fbsel_t;
  localparam int EV_CARRY  = 0;
  localparam int EV_BORROW = 1;
  localparam int EV_CMP    = 2;
  localparam int EV_INDEX  = 3;
  localparam int EV_N      = 4;
endpackage

// File: rtl/poscnt_step.sv
module poscnt_step
  import poscnt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] lim,
  input  cmode_t       mode,
  input  logic         up,
  input  logic         go,
  output logic [W-1:0] nxt,
  output logic         ev_carry,
  output logic         ev_borrow,
  output logic         ev_cmp
);
  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic moved;
  logic at_top, at_zero;

  assign at_top  = (cnt == lim);
  assign at_zero = (cnt == '0);

  always_comb begin
    nxt       = cnt;
    ev_carry  = 1'b0;
    ev_borrow = 1'b0;
    moved     = 1'b0;
    if (go) begin
      unique case (mode)
        CM_FREE, CM_ONCE: begin
          moved = 1'b1;
          if (up) begin
            nxt      = cnt + ONE;
            ev_carry = (cnt == ALL1);
          end else begin
            nxt       = cnt - ONE;
            ev_borrow = at_zero;
          end
        end
        CM_RANGE: begin
          if (up) begin
            if (at_top) ev_carry = 1'b1;
            else begin
              moved    = 1'b1;
              nxt      = cnt + ONE;
              ev_carry = (cnt == ALL1);
            end
          end else begin
            if (at_zero) ev_borrow = 1'b1;
            else begin
              moved = 1'b1;
              nxt   = cnt - ONE;
            end
          end
        end
        default: begin
          moved = 1'b1;
          if (up) begin
            if (at_top) begin
              nxt      = '0;
              ev_carry = 1'b1;
            end else begin
              nxt      = cnt + ONE;
              ev_carry = (cnt == ALL1);
            end
          end else begin
            if (at_zero) begin
              nxt       = lim;
              ev_borrow = 1'b1;
            end else nxt = cnt - ONE;
          end
        end
      endcase
    end
  end

  assign ev_cmp = moved && (nxt == lim) &&
                  (up || mode == CM_FREE || mode == CM_ONCE);
endmodule

// File: rtl/poscnt_status.sv
module poscnt_status
  import poscnt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev_set,
  input  logic            stat_clr,
  input  logic            sign_set,
  input  logic            sign_clr,
  input  logic            halt_set,
  input  logic            halt_clr,
  output logic [EV_N-1:0] sticky,
  output logic            sign,
  output logic            halted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      sign   <= 1'b0;
      halted <= 1'b0;
    end else begin
      sticky <= (stat_clr ? '0 : sticky) | ev_set;
      if (sign_clr)                sign <= 1'b0;
      else if (sign_set)           sign <= 1'b1;
      else if (ev_set[EV_BORROW])  sign <= 1'b1;
      else if (ev_set[EV_CARRY])   sign <= 1'b0;
      if (halt_clr)      halted <= 1'b0;
      else if (halt_set) halted <= 1'b1;
    end
  end

  // R9: a clear with no event in the same cycle leaves no sticky bit set
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && ev_set == '0) |=> (sticky == '0));

  // R2: a borrow event is reflected in sign unless a sign command intervenes
  a_r2_borrow_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set[EV_BORROW] && !sign_clr) |=> sign);
endmodule

// File: rtl/poscnt_flags.sv
module poscnt_flags
  import poscnt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] ev_edge,
  input  logic [EV_N-1:0] sticky,
  input  logic [EV_N-1:0] mask,
  input  logic            pulsed,
  input  logic            stat_clr,
  input  logic            sign,
  input  logic            up,
  input  fbsel_t          sel,
  output logic            flag_a_n,
  output logic            flag_b
);
  logic [EV_N-1:0] ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_edge;
  end

  assign flag_a_n = pulsed ? ~|(ev_q & mask) : ~|(sticky & mask);

  always_comb begin
    unique case (sel)
      FB_SIGN: flag_b = sign;
      FB_DIR:  flag_b = up;
      default: flag_b = 1'b1;
    endcase
  end

  // R12: with no event this cycle the pulse flag is high next cycle
  a_r12_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pulsed && ev_edge == '0) |=> (flag_a_n || !pulsed));

  // R11: a held flag stays low until status is cleared or its setup changes
  a_r11_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulsed && !flag_a_n && !stat_clr) |=>
      (!flag_a_n || pulsed || mask != $past(mask)));
endmodule

// File: rtl/poscnt_core.sv
module poscnt_core
  import poscnt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_pulse,
  input  logic         cnt_up,
  input  logic         idx_n,
  input  logic [1:0]   count_mode,
  input  logic [1:0]   idx_func,
  input  logic [3:0]   flga_mask,
  input  logic         flga_pulsed,
  input  logic [1:0]   flgb_sel,
  input  logic         count_inhibit,
  input  logic         ir_we,
  input  logic [W-1:0] ir_wdata,
  input  logic         cmd_clear,
  input  logic         cmd_load,
  input  logic         cmd_snap,
  input  logic         cmd_stat_clr,
  input  logic         cmd_sign_set,
  input  logic         cmd_sign_clr,
  output logic [W-1:0] snap_q,
  output logic [7:0]   status,
  output logic         flag_a_n,
  output logic         flag_b
);
  cmode_t mode;
  ixfn_t  ixfn;
  assign mode = cmode_t'(count_mode);
  assign ixfn = ixfn_t'(idx_func);

  logic [W-1:0] cnt_q, ir_q, nxt;
  logic idx_prev, idx_edge;
  logic do_clear, do_load, do_snap, go, enabled;
  logic ev_carry, ev_borrow, ev_cmp;
  logic [EV_N-1:0] ev_set, ev_edge, sticky;
  logic sign, halted;

  assign idx_edge = !idx_n && idx_prev;
  assign do_clear = cmd_clear || (idx_edge && ixfn == IX_CLEAR);
  assign do_load  = cmd_load  || (idx_edge && ixfn == IX_LOAD);
  assign do_snap  = cmd_snap  || (idx_edge && ixfn == IX_SNAP);
  assign enabled  = !count_inhibit && !halted;
  assign go       = cnt_pulse && enabled && !do_clear && !do_load;

  poscnt_step #(.W(W)) u_step (
    .cnt(cnt_q), .lim(ir_q), .mode(mode), .up(cnt_up), .go(go),
    .nxt(nxt), .ev_carry(ev_carry), .ev_borrow(ev_borrow), .ev_cmp(ev_cmp)
  );

  always_comb begin
    ev_set            = '0;
    ev_set[EV_CARRY]  = ev_carry;
    ev_set[EV_BORROW] = ev_borrow;
    ev_set[EV_CMP]    = ev_cmp;
    ev_set[EV_INDEX]  = !idx_n;
    ev_edge           = ev_set;
    ev_edge[EV_INDEX] = idx_edge;
  end

  poscnt_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .stat_clr(cmd_stat_clr),
    .sign_set(cmd_sign_set), .sign_clr(cmd_sign_clr),
    .halt_set(mode == CM_ONCE && (ev_carry || ev_borrow)),
    .halt_clr(do_clear || do_load),
    .sticky(sticky), .sign(sign), .halted(halted)
  );

  poscnt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ev_edge(ev_edge), .sticky(sticky),
    .mask(flga_mask), .pulsed(flga_pulsed), .stat_clr(cmd_stat_clr),
    .sign(sign), .up(cnt_up), .sel(fbsel_t'(flgb_sel)),
    .flag_a_n(flag_a_n), .flag_b(flag_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ir_q     <= '0;
      snap_q   <= '0;
      idx_prev <= 1'b1;
    end else begin
      idx_prev <= idx_n;
      if (ir_we)   ir_q   <= ir_wdata;
      if (do_snap) snap_q <= cnt_q;
      if (do_clear)     cnt_q <= '0;
      else if (do_load) cnt_q <= ir_q;
      else              cnt_q <= nxt;
    end
  end

  assign status = {sticky[EV_CARRY], sticky[EV_BORROW], sticky[EV_CMP], sticky[EV_INDEX],
                   enabled, 1'b0, cnt_up, sign};

  // R7: a host clear always leaves a zero count
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (cnt_q == '0));

  // R3: a halted single-cycle counter holds without a clear or load
  a_r3_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !cmd_clear && !cmd_load && ixfn == IX_OFF) |=> $stable(cnt_q));

  // R10: inhibit freezes the count
  a_r10_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (count_inhibit && !cmd_clear && !cmd_load && ixfn == IX_OFF) |=> $stable(cnt_q));

  // R4: range mode never climbs above the limit
  a_r4_range_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_RANGE && cnt_q <= ir_q && !ir_we) |=> (cnt_q <= ir_q));

  // R5: modulo mode stays inside 0..limit
  a_r5_wrap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_WRAP && cnt_q <= ir_q && !ir_we) |=> (cnt_q <= ir_q));
endmodule

// File: tb/poscnt_core_tb.sv
module poscnt_core_tb;
  logic clk = 0, rst_n = 0;
  logic cnt_pulse = 0, cnt_up = 0, idx_n = 1;
  logic [1:0] count_mode = 0, idx_func = 0, flgb_sel = 0;
  logic [3:0] flga_mask = 0;
  logic flga_pulsed = 0, count_inhibit = 0, ir_we = 0;
  logic [31:0] ir_wdata = 0;
  logic cmd_clear = 0, cmd_load = 0, cmd_snap = 0, cmd_stat_clr = 0, cmd_sign_set = 0, cmd_sign_clr = 0;
  logic [31:0] snap_q;
  logic [7:0] status;
  logic flag_a_n, flag_b;
  int checks = 0, failures = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  poscnt_core u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr_ir(logic [31:0] d); ir_we = 1; ir_wdata = d; cyc(); ir_we = 0; endtask
  task automatic do_load(); cmd_load = 1; cyc(); cmd_load = 0; endtask
  task automatic do_clear(); cmd_clear = 1; cyc(); cmd_clear = 0; endtask
  task automatic sclr(); cmd_stat_clr = 1; cyc(); cmd_stat_clr = 0; endtask
  task automatic snap(output logic [31:0] r); cmd_snap = 1; cyc(); cmd_snap = 0; r = snap_q; endtask
  task automatic pulse(logic up, int n);
    for (int i = 0; i < n; i++) begin cnt_pulse = 1; cnt_up = up; cyc(); cnt_pulse = 0; end
  endtask
  task automatic idx_hit(); idx_n = 0; cyc(); idx_n = 1; cyc(); endtask
  task automatic preset(logic [31:0] d); wr_ir(d); do_load(); endtask

  task automatic t_reset();
    chk("R1 snap", snap_q, 0);
    chk("R1 status", status, 8'h08);
    chk("R1 flag_a_n", flag_a_n, 1);
    chk("R1 flag_b", flag_b, 1);
    snap(v); chk("R1 count", v, 0);
  endtask

  task automatic t_free();
    count_mode = 2'b00; preset(32'hFFFF_FFFE); sclr();
    pulse(1, 2); snap(v); chk("R2 wrap up", v, 0);
    chk("R2 carry", status[7], 1);
    pulse(0, 1); snap(v); chk("R2 wrap down", v, 32'hFFFF_FFFF);
    chk("R2 borrow", status[6], 1); chk("R2 sign set", status[0], 1);
    sclr(); chk("R9 clear sticky only", status & 8'hF0, 0);
    chk("R9 sign kept", status[0], 1);
    pulse(1, 1); chk("R2 sign cleared on carry", status[0], 0);
  endtask

  task automatic t_single();
    count_mode = 2'b01; preset(32'hFFFF_FFFF); sclr();
    pulse(1, 1); chk("R3 enable drops", status[3], 0);
    pulse(1, 2); snap(v); chk("R3 halted", v, 0);
    preset(5); chk("R3 reenabled", status[3], 1);
    pulse(1, 1); snap(v); chk("R3 counts again", v, 6);
  endtask

  task automatic t_range();
    count_mode = 2'b10; wr_ir(3); do_clear(); sclr();
    pulse(1, 5); snap(v); chk("R4 top stop", v, 3);
    chk("R4 blocked carry", status[7], 1); chk("R6 cmp up range", status[5], 1);
    pulse(0, 1); snap(v); chk("R4 reverse resumes", v, 2);
    sclr(); pulse(0, 3); snap(v); chk("R4 zero stop", v, 0);
    chk("R4 blocked borrow", status[6], 1);
    pulse(1, 1); snap(v); chk("R4 up resumes", v, 1);
  endtask

  task automatic t_modulo();
    count_mode = 2'b11; wr_ir(2); do_clear(); sclr();
    pulse(1, 3); snap(v); chk("R5 up rollover", v, 0);
    chk("R5 carry", status[7], 1);
    sclr(); pulse(0, 1); snap(v); chk("R5 down reload", v, 2);
    chk("R5 borrow", status[6], 1); chk("R6 no cmp down modulo", status[5], 0);
  endtask

  task automatic t_compare();
    count_mode = 2'b00; preset(6); wr_ir(5); sclr();
    chk("R6 load no cmp", status[5], 0);
    pulse(0, 1); chk("R6 cmp down free", status[5], 1);
    count_mode = 2'b10; preset(7); wr_ir(5); sclr();
    pulse(0, 2); snap(v); chk("R6 range down value", v, 5);
    chk("R6 no cmp down range", status[5], 0);
  endtask

  task automatic t_inhibit();
    count_mode = 2'b00; preset(10); count_inhibit = 1; cyc();
    chk("R10 enable bit", status[3], 0);
    pulse(1, 3); snap(v); chk("R10 no count", v, 10);
    count_inhibit = 0;
  endtask

  task automatic t_priority();
    count_mode = 2'b00; wr_ir(9); do_clear();
    cnt_pulse = 1; cnt_up = 1; cmd_load = 1; cyc(); cnt_pulse = 0; cmd_load = 0;
    snap(v); chk("R7 load beats count", v, 9);
    cmd_clear = 1; cmd_load = 1; cyc(); cmd_clear = 0; cmd_load = 0;
    snap(v); chk("R7 clear beats load", v, 0);
    cnt_pulse = 1; cnt_up = 1; cmd_snap = 1; cyc(); cnt_pulse = 0; cmd_snap = 0;
    chk("R7 snap pre-edge", snap_q, 0);
    snap(v); chk("R7 count moved", v, 1);
  endtask

  task automatic t_index();
    count_mode = 2'b00; idx_func = 2'b01; wr_ir(32'h20); do_clear(); sclr();
    idx_hit(); chk("R8 index sticky", status[4], 1);
    snap(v); chk("R8 index load", v, 32'h20);
    idx_func = 2'b10; idx_hit(); snap(v); chk("R8 index clear", v, 0);
    idx_func = 2'b11; preset(3); idx_hit(); chk("R8 index snap", snap_q, 3);
    idx_func = 2'b00; preset(4); wr_ir(7); idx_hit(); snap(v); chk("R8 index off", v, 4);
    sclr();
  endtask

  task automatic t_flag_held();
    count_mode = 2'b00; flga_pulsed = 0; flga_mask = 4'b0001;
    preset(32'hFFFF_FFFF); sclr(); chk("R11 idle high", flag_a_n, 1);
    pulse(1, 1); chk("R11 carry low", flag_a_n, 0);
    cyc(); cyc(); cyc(); chk("R11 stays low", flag_a_n, 0);
    sclr(); chk("R11 clear releases", flag_a_n, 1);
    flga_mask = 4'b0010; do_load(); pulse(1, 1); chk("R11 masked carry", flag_a_n, 1);
    sclr();
  endtask

  task automatic t_flag_pulse();
    flga_pulsed = 1; flga_mask = 4'b0001; do_load();
    pulse(1, 1); chk("R12 pulse low", flag_a_n, 0);
    cyc(); chk("R12 pulse ends", flag_a_n, 1);
    flga_pulsed = 0; flga_mask = 0; sclr();
  endtask

  task automatic t_flagb();
    flgb_sel = 2'b01; cmd_sign_set = 1; cyc(); cmd_sign_set = 0;
    chk("R13 sign high", flag_b, 1);
    cmd_sign_clr = 1; cyc(); cmd_sign_clr = 0; chk("R13 sign low", flag_b, 0);
    flgb_sel = 2'b10; cnt_up = 1; cyc(); chk("R13 dir up", flag_b, 1);
    cnt_up = 0; cyc(); chk("R13 dir down", flag_b, 0);
    flgb_sel = 2'b00; cyc(); chk("R13 held high", flag_b, 1);
  endtask

  task automatic t_race();
    count_mode = 2'b00; preset(32'hFFFF_FFFF); sclr();
    cnt_pulse = 1; cnt_up = 1; cmd_stat_clr = 1; cyc(); cnt_pulse = 0; cmd_stat_clr = 0;
    chk("R9 event beats clear", status[7], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst_n = 1; cyc();
    t_reset(); t_free(); t_single(); t_range(); t_modulo(); t_compare();
    t_inhibit(); t_priority(); t_index(); t_flag_held(); t_flag_pulse();
    t_flagb(); t_race();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule